// File: doc/BRIEF.md
# Nine-Bit Bus Latch with Force Controls

This block is a nine-bit level-sensitive storage element that sits between a data source and a shared bus. While its gate input is high it is transparent, so each stored bit and its bus output follow the matching data input. When the gate falls, the value present at that moment is held. An active-low drive control either puts the stored word on the bus or releases all nine bus lines to high impedance. The drive control only gates the drivers and never touches the stored word.

Two asynchronous active-low force inputs override the gate and the data. One force input sets all nine stored bits to zero. The other sets all nine to one. When both are asserted, the all-ones force wins. A force that is released while the gate is low leaves the forced word held. A force that is released while the gate is high lets the data flow through again.

Control is decoded into four named modes: `MODE_ONES`, `MODE_ZERO`, `MODE_PASS` and `MODE_HOLD`. There is no clock, so the mode changes as soon as its inputs change:
- Any mode enters `MODE_ONES` when `ones_n` falls.
- Any mode other than `MODE_ONES` enters `MODE_ZERO` when `zero_n` falls.
- Releasing the forces leads to `MODE_PASS` if `gate` is high, or to `MODE_HOLD` if `gate` is low.
- `MODE_PASS` goes to `MODE_HOLD` when `gate` falls, and `MODE_HOLD` goes back to `MODE_PASS` when `gate` rises.

Top module: `bus_latch9`

## Requirements
- R1: The stored word is nine bits wide. Every bit is stored and driven independently of the others, so any nine-bit pattern passes through unchanged.
- R2: With `ones_n`=1, `zero_n`=1 and `gate`=1, the stored word equals `din` and follows every change of `din`.
- R3: When `gate` falls with both force inputs high, the word present on `din` is captured. It is held while `gate` stays low, whatever `din` does.
- R4: With `drive_n`=0, `dq` carries the stored word. With `drive_n`=1, all nine bits of `dq` are high impedance (Z).
- R5: With `zero_n`=0 and `ones_n`=1, the stored word is 9'h000, whatever `gate` and `din` are.
- R6: With `ones_n`=0, the stored word is 9'h1FF, whatever `zero_n`, `gate` and `din` are. This all-ones force has priority over the zero force.
- R7: When the force inputs are released while `gate`=0, the forced word stays held.
- R8: Changing `drive_n` never changes the stored word. This includes a force applied while the outputs are in high impedance: the forced word appears as soon as `drive_n` returns to 0.
- R9: When the force inputs are released while `gate`=1, the latch becomes transparent again and the stored word equals `din`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| din | input | 9 | Data to be stored |
| gate | input | 1 | Transparency control: high means transparent, and the falling edge captures |
| ones_n | input | 1 | Asynchronous force to all ones, active low, highest priority |
| zero_n | input | 1 | Asynchronous force to all zeros, active low |
| drive_n | input | 1 | Bus drive control, active low: 1 puts all outputs in high impedance |
| dq | output | 9 | Bus outputs carrying the stored word |

## Verification
The assertions are immediate checks that run when the combinational logic settles. They rely on the inputs staying at stable known levels between changes, and on `din` not changing in the same instant that `gate` falls, because capture at that instant is a timing matter outside this block. The stimulus changes the inputs only at one point in each clock period, well away from the sampling instant. Before every capture it sets the data first and then lowers the gate. In the exhaustive sweep it reloads a known word before each combination, so every case starts from a defined stored value.

// File: rtl/buslatch_pkg.sv
package buslatch_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD = 2'd0,
        MODE_PASS = 2'd1,
        MODE_ZERO = 2'd2,
        MODE_ONES = 2'd3
    } latch_mode_t;
endpackage

// File: rtl/buslatch_ctrl.sv
module buslatch_ctrl
    import buslatch_pkg::*;
(
    input  logic        ones_n,
    input  logic        zero_n,
    input  logic        gate,
    output latch_mode_t mode
);
    // Priority: all-ones force, then zero force, then gate level.
    always_comb begin
        unique casez ({ones_n, zero_n, gate})
            3'b0??:  mode = MODE_ONES;
            3'b10?:  mode = MODE_ZERO;
            3'b111:  mode = MODE_PASS;
            3'b110:  mode = MODE_HOLD;
            default: mode = MODE_HOLD;
        endcase
    end
endmodule

// File: rtl/buslatch_store.sv
module buslatch_store
    import buslatch_pkg::*;
#(
    parameter int WIDTH = 9
) (
    input  latch_mode_t      mode,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic bit_q;
        always_latch begin
            unique case (mode)
                MODE_ONES: bit_q = 1'b1;
                MODE_ZERO: bit_q = 1'b0;
                MODE_PASS: bit_q = din[i];
                MODE_HOLD: ;
            endcase
        end
        assign q[i] = bit_q;
    end
endmodule

// File: rtl/buslatch_drive.sv
module buslatch_drive #(
    parameter int WIDTH = 9
) (
    input  logic             drive_n,
    input  logic [WIDTH-1:0] q,
    output logic [WIDTH-1:0] dq
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_drv
        assign dq[i] = drive_n ? 1'bz : q[i];
    end
endmodule

// File: rtl/bus_latch9.sv
module bus_latch9
    import buslatch_pkg::*;
#(
    parameter int WIDTH = 9
) (
    input  logic [WIDTH-1:0] din,
    input  logic             gate,
    input  logic             ones_n,
    input  logic             zero_n,
    input  logic             drive_n,
    output logic [WIDTH-1:0] dq
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ALL_ZERO = '0;

    latch_mode_t      mode;
    logic [WIDTH-1:0] stored;

    buslatch_ctrl u_ctrl (
        .ones_n (ones_n),
        .zero_n (zero_n),
        .gate   (gate),
        .mode   (mode)
    );

    buslatch_store #(.WIDTH(WIDTH)) u_store (
        .mode (mode),
        .din  (din),
        .q    (stored)
    );

    buslatch_drive #(.WIDTH(WIDTH)) u_drive (
        .drive_n (drive_n),
        .q       (stored),
        .dq      (dq)
    );

    // Port-level checks spanning decode, storage and drivers.
    always_comb begin
        if (!ones_n) begin
            p_ones_store_r6: assert (stored == ALL_ONES)
                else $error("R6 stored word not all ones under force");
        end
        if (!ones_n && !drive_n) begin
            p_ones_bus_r6: assert (dq == ALL_ONES)
                else $error("R6 bus not all ones under force");
        end
        if (ones_n && !zero_n && !drive_n) begin
            p_zero_bus_r5: assert (dq == ALL_ZERO)
                else $error("R5 bus not zero under force");
        end
        if (ones_n && zero_n && gate && !drive_n) begin
            p_pass_bus_r2: assert (dq == din)
                else $error("R2 bus does not follow data while transparent");
        end
    end
endmodule

// File: tb/tb_bus_latch9.sv
module tb_bus_latch9;
    localparam int W = 9;
    localparam logic [W-1:0] ZZ = {W{1'bz}};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] din = '0;
    logic         gate = 1'b0;
    logic         ones_n = 1'b1;
    logic         zero_n = 1'b1;
    logic         drive_n = 1'b1;
    wire  [W-1:0] dq;

    int checks = 0;
    int fails = 0;
    logic [W-1:0] mq = '0;
    bit done = 1'b0;

    bus_latch9 #(.WIDTH(W)) dut (
        .din(din), .gate(gate), .ones_n(ones_n), .zero_n(zero_n),
        .drive_n(drive_n), .dq(dq)
    );

    always #10 clk = ~clk;

    // Watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Drive at the falling edge, update the reference model.
    task automatic apply(input logic o, input logic z, input logic dr,
                         input logic g, input logic [W-1:0] d);
        @(negedge clk);
        din = d; ones_n = o; zero_n = z; drive_n = dr; gate = g;
        if (!o) mq = '1;
        else if (!z) mq = '0;
        else if (g) mq = d;
        #5;
    endtask

    task automatic chk(input string tag, input logic [W-1:0] exp);
        checks++;
        if (dq !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, dq, exp);
        end
    endtask

    // Drive the stored word to the bus to observe it.
    task automatic show(input string tag);
        @(negedge clk);
        drive_n = 1'b0;
        #5;
        chk(tag, mq);
    endtask

    task automatic t_reset_state();
        #5;
        chk("R4 reset high-Z", ZZ);
    endtask

    task automatic t_patterns();
        apply(1, 1, 0, 1, 9'h1A5); chk("R1 pattern 1A5", 9'h1A5);
        apply(1, 1, 0, 1, 9'h05A); chk("R1 pattern 05A", 9'h05A);
        apply(1, 1, 0, 1, 9'h100); chk("R1 msb only", 9'h100);
        apply(1, 1, 0, 1, 9'h001); chk("R2 follows data", 9'h001);
    endtask

    task automatic t_capture();
        apply(1, 1, 0, 1, 9'h0C3);
        apply(1, 1, 0, 0, 9'h0C3); chk("R3 captured", 9'h0C3);
        apply(1, 1, 0, 0, 9'h13C); chk("R3 hold ignores din", 9'h0C3);
    endtask

    task automatic t_drive();
        apply(1, 1, 1, 0, 9'h13C); chk("R4 all nine Z", ZZ);
        apply(1, 1, 0, 0, 9'h000); chk("R8 value kept across drive toggle", 9'h0C3);
    endtask

    task automatic t_zero();
        apply(1, 0, 0, 1, 9'h1FF); chk("R5 zero with gate high", 9'h000);
        apply(1, 0, 0, 0, 9'h155); chk("R5 zero with gate low", 9'h000);
        apply(1, 1, 0, 0, 9'h155); chk("R7 zero held after release", 9'h000);
    endtask

    task automatic t_ones();
        apply(0, 1, 0, 1, 9'h000); chk("R6 ones with gate high", 9'h1FF);
        apply(0, 0, 0, 0, 9'h000); chk("R6 ones beats zero", 9'h1FF);
        apply(1, 0, 0, 0, 9'h0AA); chk("R5 zero after ones released", 9'h000);
        apply(0, 1, 0, 0, 9'h0AA);
        apply(1, 1, 0, 0, 9'h0AA); chk("R7 ones held after release", 9'h1FF);
    endtask

    task automatic t_hidden_force();
        apply(1, 0, 1, 0, 9'h0F0); chk("R4 Z during hidden force", ZZ);
        apply(1, 1, 1, 0, 9'h0F0);
        show("R8 hidden zero force visible");
    endtask

    task automatic t_release_high();
        apply(1, 0, 0, 1, 9'h0E7); chk("R5 forced under gate high", 9'h000);
        apply(1, 1, 0, 1, 9'h0E7); chk("R9 transparent after release", 9'h0E7);
        apply(1, 1, 0, 1, 9'h118); chk("R9 follows new data", 9'h118);
    endtask

    task automatic t_sweep();
        for (int k = 0; k < 16; k++) begin
            logic o, z, dr, g;
            string tag;
            {o, z, dr, g} = 4'(k);
            apply(1, 1, 0, 1, 9'h0B6);
            apply(1, 1, 0, 0, 9'h0B6);
            apply(o, z, dr, g, 9'h149);
            if (!o) tag = "R6 sweep";
            else if (!z) tag = "R5 sweep";
            else if (g) tag = "R2 sweep";
            else tag = "R3 sweep";
            chk(tag, dr ? ZZ : mq);
            if (dr) show("R8 sweep stored value");
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_patterns();
        t_capture();
        t_drive();
        t_zero();
        t_ones();
        t_hidden_force();
        t_release_high();
        t_sweep();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule